// File: doc/BRIEF.md
# Staged Reset Sequencer

This block merges the reset triggers of one clock domain into the reset outputs of that domain. Two active-low trigger pins start a reset: a power-good monitor and a test/simulation reset. A small write port loads a register of soft-reset bits, one bit per sub-block, and each set bit holds its sub-block in reset. Any trigger pin going low forces every output into reset at once, with no clock running. Release is aligned to the clock through a two-stage synchronizer. The output of that synchronizer forms a reset domain of its own.

Reset is released in two tiers. The peripheral reset releases first. The processor reset stays asserted for `HOLD_CYCLES` further clock edges, so that slow start-up work can finish first. Memory repair is one example of such work. Each reset comes as a pair: an active-low output that asserts asynchronously and an active-high output that asserts synchronously. A scan-mode input gates off every path from a flop into an asynchronous reset output. The gated term is then combined with the raw trigger pins with an AND, so the asynchronous reset can still be tested in scan mode.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwr_ok_n` or `test_rst_n` is low, the design drives `periph_rst_n`, `cpu_rst_n` and every `sub_rst_n` bit low, and `periph_srst`, `cpu_srst` and every `sub_srst` bit high. This takes effect without any clock edge.
- R2: After both trigger pins are high, `periph_rst_n` rises and `periph_srst` falls together, on the second rising clock edge.
- R3: `cpu_rst_n` rises and `cpu_srst` falls together, exactly `HOLD_CYCLES` rising edges after the peripheral reset is released.
- R4: On a rising edge with `sr_we` high, the soft-reset register loads `sr_wdata`. Bit k of the register controls only `sub_rst_n[k]` and `sub_srst[k]`, and a value of 1 means the sub-block is in reset.
- R5: `sub_rst_n[k]` falls right after the edge that loads a 1 into bit k. `sub_srst[k]` rises one edge later. After the edge that loads a 0 into bit k, both outputs are released together on the next edge.
- R6: A low on either trigger pin clears the soft-reset bits. Soft-reset bits do not affect `periph_*` or `cpu_*` once the processor reset has been released.
- R7: If any soft-reset bit is active during the processor hold-off, the hold-off count restarts. The processor is then released `HOLD_CYCLES` edges after the last soft release.
- R8: A soft-reset write that lands on the final hold-off edge does not delay the processor release.
- R9: When `scan_mode` is high, `periph_rst_n`, `cpu_rst_n` and `sub_rst_n` follow only the trigger pins. The active-high synchronous outputs are not affected by `scan_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| pwr_ok_n | input | 1 | Power-good monitor; low while the supply rails are not yet settled |
| test_rst_n | input | 1 | Test/simulation reset, active low |
| scan_mode | input | 1 | Scan test mode; gates flop-driven terms out of the asynchronous outputs |
| sr_we | input | 1 | Write enable for the soft-reset register |
| sr_wdata | input | NSUB | New soft-reset bits; bit k = 1 puts sub-block k in reset |
| periph_rst_n | output | 1 | Peripheral reset, asynchronous, active low |
| periph_srst | output | 1 | Peripheral reset, synchronous, active high |
| cpu_rst_n | output | 1 | Processor reset, asynchronous, active low |
| cpu_srst | output | 1 | Processor reset, synchronous, active high |
| sub_rst_n | output | NSUB | Per-sub-block reset, asynchronous, active low |
| sub_srst | output | NSUB | Per-sub-block reset, synchronous, active high |

## Verification
The end of the processor hold-off count and a soft-reset write can land on the same clock edge. The bench provokes this by counting `HOLD_CYCLES-1` falling edges after the peripheral release and then raising `sr_we`, so that the write and the final count edge coincide. The result is judged correct only if `cpu_rst_n` is high after that edge while the newly written sub-block is already held low. A separate scenario spreads a soft pulse across the hold-off window and checks that the count restarts from the soft release.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int NSUB        = 4,
  parameter int HOLD_CYCLES = 3000
) (
  input  logic            clk,
  input  logic            pwr_ok_n,
  input  logic            test_rst_n,
  input  logic            scan_mode,
  input  logic            sr_we,
  input  logic [NSUB-1:0] sr_wdata,
  output logic            periph_rst_n,
  output logic            periph_srst,
  output logic            cpu_rst_n,
  output logic            cpu_srst,
  output logic [NSUB-1:0] sub_rst_n,
  output logic [NSUB-1:0] sub_srst
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic            trig_n;
  logic            meta_q, filt_q;
  logic [NSUB-1:0] soft_q, soft_d;
  logic            soft_busy;
  logic [CW-1:0]   cnt;
  logic            go;

  assign trig_n    = pwr_ok_n & test_rst_n;
  assign soft_busy = |(soft_q | soft_d);

  always_ff @(posedge clk or negedge trig_n) begin
    if (!trig_n) begin
      meta_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      filt_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge trig_n) begin
    if (!trig_n) begin
      soft_q <= '0;
      soft_d <= '0;
    end else begin
      if (sr_we) soft_q <= sr_wdata;
      soft_d <= soft_q;
    end
  end

  always_ff @(posedge clk or negedge trig_n) begin
    if (!trig_n) begin
      cnt <= '0;
      go  <= 1'b0;
    end else if (!go) begin
      if (!filt_q || soft_busy)
        cnt <= '0;
      else if (cnt == CW'(HOLD_CYCLES - 1))
        go <= 1'b1;
      else
        cnt <= cnt + CW'(1);
    end
  end

  assign periph_rst_n = trig_n & (filt_q | scan_mode);
  assign periph_srst  = ~filt_q;
  assign cpu_rst_n    = trig_n & (go | scan_mode);
  assign cpu_srst     = ~go;
  assign sub_rst_n    = {NSUB{periph_rst_n}} & (~(soft_q | soft_d) | {NSUB{scan_mode}});
  assign sub_srst     = {NSUB{periph_srst}} | soft_d;

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int NSUB = 4
) (
  input logic            clk,
  input logic            pwr_ok_n,
  input logic            test_rst_n,
  input logic            scan_mode,
  input logic            periph_rst_n,
  input logic            periph_srst,
  input logic            cpu_rst_n,
  input logic            cpu_srst,
  input logic [NSUB-1:0] sub_rst_n,
  input logic [NSUB-1:0] sub_srst
);

  logic trig_n;
  assign trig_n = pwr_ok_n & test_rst_n;

  p_trig_forces_r1: assert property (@(posedge clk)
    !trig_n |-> (!periph_rst_n && !cpu_rst_n && periph_srst && cpu_srst));

  p_periph_pair_r2: assert property (@(posedge clk) disable iff (!trig_n || scan_mode)
    $fell(periph_srst) |-> $rose(periph_rst_n));

  p_cpu_after_periph_r3: assert property (@(posedge clk) disable iff (!trig_n)
    $fell(cpu_srst) |-> (!periph_srst && $past(!periph_srst)));

  p_cpu_covers_periph_r3: assert property (@(posedge clk) disable iff (!trig_n)
    periph_srst |-> cpu_srst);

  p_scan_gate_r9: assert property (@(posedge clk) disable iff (!trig_n)
    scan_mode |-> (periph_rst_n && cpu_rst_n && (&sub_rst_n)));

  for (genvar k = 0; k < NSUB; k++) begin : g_bit
    p_async_leads_r5: assert property (@(posedge clk) disable iff (!trig_n || scan_mode)
      (sub_srst[k] && !$past(sub_srst[k]) && !periph_srst) |-> !$past(sub_rst_n[k]));

    p_release_pair_r5: assert property (@(posedge clk) disable iff (!trig_n || scan_mode)
      $rose(sub_rst_n[k]) |-> $fell(sub_srst[k]));
  end

endmodule

bind rst_sequencer rst_sequencer_chk #(.NSUB(NSUB)) u_chk (
  .clk(clk), .pwr_ok_n(pwr_ok_n), .test_rst_n(test_rst_n), .scan_mode(scan_mode),
  .periph_rst_n(periph_rst_n), .periph_srst(periph_srst),
  .cpu_rst_n(cpu_rst_n), .cpu_srst(cpu_srst),
  .sub_rst_n(sub_rst_n), .sub_srst(sub_srst)
);

// File: tb/tb_rst_sequencer.sv
`timescale 1ns/1ps
module tb_rst_sequencer;
  localparam int NSUB = 4;
  localparam int HOLD = 40;

  logic clk = 1'b0, clk_en = 1'b1;
  logic pwr_ok_n = 1'b0, test_rst_n = 1'b1, scan_mode = 1'b0, sr_we = 1'b0;
  logic [NSUB-1:0] sr_wdata = '0;
  logic periph_rst_n, periph_srst, cpu_rst_n, cpu_srst;
  logic [NSUB-1:0] sub_rst_n, sub_srst;
  int checks = 0, fails = 0;
  bit done = 0;

  always begin #2; if (clk_en) clk = ~clk; end

  rst_sequencer #(.NSUB(NSUB), .HOLD_CYCLES(HOLD)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all_held(string req);
    chk(req, {periph_rst_n, cpu_rst_n, sub_rst_n}, '0);
    chk(req, {periph_srst, cpu_srst, sub_srst}, {(NSUB+2){1'b1}});
  endtask

  task automatic release_triggers();
    @(negedge clk); pwr_ok_n = 1'b1; test_rst_n = 1'b1;
    @(negedge clk);
    chk("R2 one edge after release", {periph_rst_n, periph_srst}, 2'b01);
    @(negedge clk);
    chk("R2 two edges after release", {periph_rst_n, periph_srst, cpu_rst_n, cpu_srst}, 4'b1001);
  endtask

  task automatic wait_cpu(string req);
    int n = 0;
    while (cpu_rst_n === 1'b0 && n < 10000) begin @(negedge clk); n++; end
    chk(req, n, HOLD);
    chk(req, cpu_srst, 1'b0);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk_all_held("R1 power-good low at start");
    release_triggers();
    wait_cpu("R3 hold-off after power-good release");
  endtask

  task automatic t_async_noclk();
    @(negedge clk); clk_en = 1'b0;
    #5 pwr_ok_n = 1'b0;
    #3 chk_all_held("R1 power-good low, clock stopped");
    pwr_ok_n = 1'b1; #5 test_rst_n = 1'b0;
    #3 chk_all_held("R1 test reset low, clock stopped");
    clk_en = 1'b1;
    release_triggers();
    wait_cpu("R3 hold-off after test reset release");
  endtask

  task automatic t_soft_pulse();
    @(negedge clk); sr_we = 1'b1; sr_wdata = 4'b0100;
    @(negedge clk); sr_wdata = 4'b0000;
    chk("R5 async asserts first", {sub_rst_n[2], sub_srst[2]}, 2'b00);
    chk("R4 other bits untouched", sub_rst_n, 4'b1011);
    @(negedge clk); sr_we = 1'b0;
    chk("R5 sync follows one edge later", {sub_rst_n[2], sub_srst[2]}, 2'b01);
    chk("R6 cpu and periph unaffected", {periph_rst_n, periph_srst, cpu_rst_n, cpu_srst}, 4'b1010);
    @(negedge clk);
    chk("R5 both release on same edge", {sub_rst_n, sub_srst}, {4'b1111, 4'b0000});
  endtask

  task automatic t_soft_cleared();
    @(negedge clk); sr_we = 1'b1; sr_wdata = 4'b0010;
    @(negedge clk); sr_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 bit 1 held in reset", {sub_rst_n, sub_srst}, {4'b1101, 4'b0010});
    pwr_ok_n = 1'b0;
    repeat (2) @(negedge clk);
    release_triggers();
    chk("R6 soft bits cleared by power-good", {sub_rst_n, sub_srst}, {4'b1111, 4'b0000});
    wait_cpu("R3 hold-off after clear");
  endtask

  task automatic t_restart();
    @(negedge clk); test_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    release_triggers();
    repeat (5) @(negedge clk);
    sr_we = 1'b1; sr_wdata = 4'b0001;
    @(negedge clk); sr_wdata = 4'b0000;
    @(negedge clk); sr_we = 1'b0;
    chk("R7 cpu held during soft pulse", cpu_rst_n, 1'b0);
    @(negedge clk);
    chk("R7 soft released", sub_rst_n[0], 1'b1);
    wait_cpu("R7 hold-off restarts after soft release");
  endtask

  task automatic t_same_edge();
    @(negedge clk); pwr_ok_n = 1'b0;
    repeat (2) @(negedge clk);
    release_triggers();
    repeat (HOLD - 1) @(negedge clk);
    sr_we = 1'b1; sr_wdata = 4'b0100;
    @(negedge clk); sr_we = 1'b0;
    chk("R8 cpu released on final edge despite write", {cpu_rst_n, cpu_srst}, 2'b10);
    chk("R8 written sub-block in reset", sub_rst_n[2], 1'b0);
    @(negedge clk); sr_we = 1'b1; sr_wdata = 4'b0000;
    @(negedge clk); sr_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 cpu stays released after soft clear", {cpu_rst_n, sub_rst_n}, 5'b11111);
  endtask

  task automatic t_scan();
    @(negedge clk); scan_mode = 1'b1; sr_we = 1'b1; sr_wdata = 4'b1000;
    @(negedge clk); sr_we = 1'b0;
    @(negedge clk);
    chk("R9 async sub reset gated in scan", sub_rst_n, 4'b1111);
    chk("R9 sync sub reset unaffected by scan", sub_srst, 4'b1000);
    pwr_ok_n = 1'b0;
    #1 chk("R9 trigger still reaches async outputs", {periph_rst_n, cpu_rst_n, sub_rst_n}, '0);
    repeat (2) @(negedge clk);
    pwr_ok_n = 1'b1;
    #1 chk("R9 async outputs follow trigger only", {periph_rst_n, cpu_rst_n, periph_srst, cpu_srst}, 4'b1111);
    @(negedge clk); scan_mode = 1'b0;
    @(negedge clk);
    chk("R2 periph released after scan exit", {periph_rst_n, periph_srst}, 2'b10);
    wait_cpu("R3 hold-off after scan exit");
  endtask

  initial begin
    t_reset_state();
    t_async_noclk();
    t_soft_pulse();
    t_soft_cleared();
    t_restart();
    t_same_edge();
    t_scan();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule